// File: doc/BRIEF.md
# Serial Binary-to-BCD Doubling Converter

This block turns a 7-bit binary value between 0 and 99 into two packed BCD digits, tens and ones, ready for a two-digit numeric display. It works one bit per clock. The decimal register is doubled at each step, and the next binary bit, taken most significant first, is added in as the low bit. Before each doubling, a lower digit holding 5 or more is raised by 3. This makes the doubled value carry into the digit above it. The top digit never passes 9 for an input of 99 or less, so it has no correction logic.

A start pulse given while the block is idle captures the operand. Seven shift steps follow. A one-cycle done pulse then marks the result, which stays on the output until the next accepted start. The only thing a digit passes to the digit above it in a step is its own registered top bit after correction. A carry therefore moves up by at most one digit per clock, and no carry chain runs across digits.

Top module: `bcd2_serial_conv`

## Requirements
- R1: After a synchronous active-high reset, `busy_o` is 0, `done_o` is 0 and `bcd_o` is 8'h00.
- R2: When `start_i` is high on a clock edge while `busy_o` is 0, the block captures `bin_i` and shows `busy_o` high after that edge.
- R3: `done_o` goes high after exactly 8 clock edges, counting the edge that captured the start: one load and 7 shift steps. It stays high for a single cycle, and `busy_o` is 0 in that cycle.
- R4: For every input v from 0 to 99, the result once done holds tens = v/10 in `bcd_o[7:4]` and ones = v%10 in `bcd_o[3:0]`.
- R5: An input of 97 yields `bcd_o[7:4]` = 4'b1001 and `bcd_o[3:0]` = 4'b0111.
- R6: `start_i` is ignored while `busy_o` is 1. It changes neither the operand being converted nor the timing of `done_o`.
- R7: While the block is idle and `start_i` is low, `bcd_o` stays constant, whatever `bin_i` does.
- R8: Every 4-bit digit of `bcd_o` holds a value of 9 or less in every cycle, during conversion as well as after it.
- R9: A reset during a conversion aborts it. `busy_o` and `done_o` drop to 0, `bcd_o` returns to 8'h00, and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, sampled only while idle |
| bin_i | input | 7 | Binary operand, 0 to 99 |
| busy_o | output | 1 | High while shift steps are in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| bcd_o | output | 8 | Result: tens in [7:4], ones in [3:0] |

## Verification
The hardest case to reach from the ports is a start request that arrives while a conversion is running. It only shows up as a wrong operand or a shifted done pulse. The bench therefore raises `start_i`, with the operand's bitwise complement, in the middle of some sweep conversions. It then checks both the result and the exact latency against the operand captured first. A reset in the middle of a conversion is forced the same way. The bench confirms that no done pulse leaks out afterwards. All 100 legal operands are swept and compared with integer division and remainder by 10. The digit range is sampled on every cycle of every conversion.

// File: rtl/bcd2_pkg.sv
package bcd2_pkg;

    localparam int BIN_W_DEF  = 7;
    localparam int DIGITS_DEF = 2;
    localparam int DIG_W      = 4;

    typedef logic [DIG_W-1:0] digit_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } conv_state_e;

    typedef struct packed {
        logic   cin;
        digit_t cur;
    } cell_in_t;

    typedef struct packed {
        logic   cout;
        digit_t nxt;
    } cell_out_t;

    // Decimal pre-correction: a digit of five or more gets three added
    // so that doubling it produces a carry and a valid low digit.
    function automatic digit_t dig_fix(input digit_t d);
        digit_t r;
        if (d >= digit_t'(5)) r = d + digit_t'(3);
        else                  r = d;
        return r;
    endfunction

    function automatic logic dig_valid(input digit_t d);
        return (d <= digit_t'(9));
    endfunction

endpackage

// File: rtl/bcd2_digit_cell.sv
module bcd2_digit_cell
    import bcd2_pkg::*;
#(
    parameter bit HAS_CORR = 1'b1
) (
    input  cell_in_t  cell_i,
    output cell_out_t cell_o
);

    digit_t fixed;

    generate
        if (HAS_CORR) begin : g_corr
            always_comb fixed = dig_fix(cell_i.cur);
        end else begin : g_plain
            always_comb fixed = cell_i.cur;
        end
    endgenerate

    always_comb begin
        cell_o.cout = fixed[DIG_W-1];
        cell_o.nxt  = {fixed[DIG_W-2:0], cell_i.cin};
    end

endmodule

// File: rtl/bcd2_step_ctrl.sv
module bcd2_step_ctrl
    import bcd2_pkg::*;
#(
    parameter int BIN_W = BIN_W_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = (BIN_W > 1) ? $clog2(BIN_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIN_W - 1);

    conv_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    always_comb begin
        load_o = (state_q == ST_IDLE) && start_i;
        step_o = (state_q == ST_RUN);
        busy_o = (state_q == ST_RUN);
        done_o = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bcd2_shift_path.sv
module bcd2_shift_path
    import bcd2_pkg::*;
#(
    parameter int BIN_W  = BIN_W_DEF,
    parameter int DIGITS = DIGITS_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic                    step_i,
    input  logic [BIN_W-1:0]        bin_i,
    output logic [DIGITS*DIG_W-1:0] bcd_o
);

    logic [BIN_W-1:0]          bin_sr_q;
    digit_t [DIGITS-1:0]       dig_q;
    cell_in_t  [DIGITS-1:0]    c_in;
    cell_out_t [DIGITS-1:0]    c_out;

    // Each digit only sees the registered top bit of the digit below,
    // after that digit's own correction: no chain beyond one digit.
    generate
        for (genvar d = 0; d < DIGITS; d++) begin : g_dig
            if (d == 0) begin : g_lo
                assign c_in[d].cin = bin_sr_q[BIN_W-1];
            end else begin : g_up
                assign c_in[d].cin = c_out[d-1].cout;
            end
            assign c_in[d].cur = dig_q[d];

            bcd2_digit_cell #(
                .HAS_CORR(d < DIGITS - 1)
            ) u_cell (
                .cell_i(c_in[d]),
                .cell_o(c_out[d])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_sr_q <= '0;
            dig_q    <= '0;
        end else if (load_i) begin
            bin_sr_q <= bin_i;
            dig_q    <= '0;
        end else if (step_i) begin
            bin_sr_q <= {bin_sr_q[BIN_W-2:0], 1'b0};
            for (int d = 0; d < DIGITS; d++) dig_q[d] <= c_out[d].nxt;
        end
    end

    assign bcd_o = dig_q;

endmodule

// File: rtl/bcd2_serial_conv.sv
module bcd2_serial_conv
    import bcd2_pkg::*;
#(
    parameter int BIN_W  = BIN_W_DEF,
    parameter int DIGITS = DIGITS_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [BIN_W-1:0]        bin_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [DIGITS*DIG_W-1:0] bcd_o
);

    logic load_w;
    logic step_w;

    bcd2_step_ctrl #(
        .BIN_W(BIN_W)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .load_o (load_w),
        .step_o (step_w),
        .busy_o (busy_o),
        .done_o (done_o)
    );

    bcd2_shift_path #(
        .BIN_W (BIN_W),
        .DIGITS(DIGITS)
    ) u_path (
        .clk   (clk),
        .rst   (rst),
        .load_i(load_w),
        .step_i(step_w),
        .bin_i (bin_i),
        .bcd_o (bcd_o)
    );

endmodule

// File: rtl/bcd2_conv_chk.sv
module bcd2_conv_chk
    import bcd2_pkg::*;
#(
    parameter int BIN_W  = BIN_W_DEF,
    parameter int DIGITS = DIGITS_DEF
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start_i,
    input logic                    busy_o,
    input logic                    done_o,
    input logic [DIGITS*DIG_W-1:0] bcd_o
);

    localparam int CW = $clog2(BIN_W + 2) + 1;

    logic [CW-1:0] steps_q;
    logic          digits_ok;

    always_ff @(posedge clk) begin
        if (rst)                    steps_q <= '0;
        else if (start_i && !busy_o) steps_q <= '0;
        else if (busy_o)            steps_q <= steps_q + 1'b1;
    end

    always_comb begin
        digits_ok = 1'b1;
        for (int d = 0; d < DIGITS; d++)
            if (!dig_valid(bcd_o[d*DIG_W +: DIG_W])) digits_ok = 1'b0;
    end

    assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_latency_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (steps_q == CW'(BIN_W) && !busy_o));

    assert_busy_continues_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_o && steps_q < CW'(BIN_W - 1)) |=> (busy_o && !done_o));

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(bcd_o));

    assert_digit_range_R8: assert property (@(posedge clk) disable iff (rst)
        digits_ok);

endmodule

bind bcd2_serial_conv bcd2_conv_chk #(
    .BIN_W (BIN_W),
    .DIGITS(DIGITS)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .bcd_o  (bcd_o)
);

// File: tb/tb_bcd2_serial_conv.sv
module tb_bcd2_serial_conv;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [6:0] bin_i = '0;
    logic       busy_o;
    logic       done_o;
    logic [7:0] bcd_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    bcd2_serial_conv dut (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .bin_i  (bin_i),
        .busy_o (busy_o),
        .done_o (done_o),
        .bcd_o  (bcd_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Converts v; with stray set, requests a new start with ~v mid-run.
    task automatic run_conv(input int v, input bit stray);
        int lat = 0;
        bit range_ok = 1'b1;
        @(negedge clk);
        start_i = 1'b1;
        bin_i   = 7'(v);
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        check("R2 busy after start", int'(busy_o), 1);
        for (int i = 0; i < 20; i++) begin
            if (done_o) break;
            if (bcd_o[7:4] > 4'd9 || bcd_o[3:0] > 4'd9) range_ok = 1'b0;
            if (stray && lat == 3) begin
                start_i = 1'b1;
                bin_i   = ~7'(v);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        check(stray ? "R6 latency with stray start" : "R3 latency", lat, 8);
        check("R3 busy low at done", int'(busy_o), 0);
        check("R8 digit range during run", int'(range_ok), 1);
        check(stray ? "R6 tens with stray start" : "R4 tens", int'(bcd_o[7:4]), v / 10);
        check(stray ? "R6 ones with stray start" : "R4 ones", int'(bcd_o[3:0]), v % 10);
        @(negedge clk);
        check("R3 done one cycle", int'(done_o), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<100000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 busy", int'(busy_o), 0);
        check("R1 done", int'(done_o), 0);
        check("R1 bcd", int'(bcd_o), 0);

        // R5 single known value
        run_conv(97, 1'b0);
        check("R5 tens 1001", int'(bcd_o[7:4]), 9);
        check("R5 ones 0111", int'(bcd_o[3:0]), 7);

        // R4 full sweep, R6 stray starts on every seventh operand
        for (int v = 0; v < 100; v++) run_conv(v, (v % 7) == 3);

        // R7 hold while idle with a changing operand
        run_conv(58, 1'b0);
        for (int k = 0; k < 6; k++) begin
            bin_i = 7'(k * 13);
            @(negedge clk);
            check("R7 hold", int'(bcd_o), 8'h58);
        end

        // R9 reset mid-conversion
        @(negedge clk);
        start_i = 1'b1;
        bin_i   = 7'd77;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 busy cleared", int'(busy_o), 0);
        check("R9 done cleared", int'(done_o), 0);
        check("R9 bcd cleared", int'(bcd_o), 0);
        begin
            int seen = 0;
            for (int k = 0; k < 12; k++) begin
                if (done_o) seen++;
                @(negedge clk);
            end
            check("R9 no late done", seen, 0);
        end

        // conversion works after the abort
        run_conv(99, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule